// File: doc/BRIEF.md
# Watchdog Timer with Selectable Fault Actions

This block is a watchdog for an embedded controller. Software arms it through a configuration strobe that carries an enable bit, a 4-bit period code and a 3-bit action mask. While armed, a prescaler divides the system clock down to a 1 µs tick, and a down-counter loaded with the chosen period falls by one on every tick. Software must pulse the service input before the counter runs out. If it does not, the timer expires.

On expiry the block sets a sticky timeout status bit. It also fires whichever fault outputs the action mask selects: a system-wide reset pulse, a local reset pulse, and a board-fail level that stays on until software clears it. After an expiry the timer reloads and keeps running for as long as it stays armed. Writing the configuration with the enable bit low stops the count at once.

Top module: `wdog_top`

## Requirements
- R1: After reset, and for as long as the timer has not been armed, every fault output and the timeout status are low and no expiry occurs.
- R2: A configuration write with the enable bit high (re)starts the count at the full period. The timeout status rises at the clock edge that lies period_ticks × CLK_PER_US cycles after the edge that captured the write.
- R3: period_ticks equals BASE_US × 2^code, where code is the 4-bit period field (code 0 gives BASE_US ticks).
- R4: A service strobe while armed reloads the full period and restarts the prescaler. The next expiry then falls period_ticks × CLK_PER_US cycles after the edge that captured the strobe. This holds even when the strobe arrives in the last cycle before the timer would have expired.
- R5: A service strobe while the timer is disarmed has no effect.
- R6: Action mask bit 0 selects the system reset, bit 1 the local reset and bit 2 the board-fail output. On expiry only the selected outputs fire. An unselected output never rises.
- R7: Each reset output, once fired, stays high for RST_PULSE cycles (at least 16).
- R8: Board-fail stays asserted until a status-clear strobe. The strobe clears board-fail and the timeout status on the next edge. If a new expiry lands in the same cycle as the strobe, the set wins.
- R9: The timeout status is sticky: it stays high after expiry, through disarming, until it is cleared.
- R10: A configuration write with the enable bit low stops the count and cancels any expiry. This includes a write captured on the very edge at which the timer would have expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable bit written with the strobe |
| cfg_period_i | input | 4 | Period code written with the strobe |
| cfg_act_i | input | 3 | Action mask: bit0 system reset, bit1 local reset, bit2 board-fail |
| kick_i | input | 1 | Service strobe |
| sts_clr_i | input | 1 | Clear strobe for timeout status and board-fail |
| sys_rst_o | output | 1 | System reset pulse |
| loc_rst_o | output | 1 | Local reset pulse |
| board_fail_o | output | 1 | Board-fail level |
| timeout_o | output | 1 | Sticky timeout status |

## Verification
The bench drives the countdown with several patterns and predicts the exact expiry cycle for each. Different period codes separate the power-of-two table entries from one another. Chains of service strobes, the last one in the final cycle before expiry, show that servicing reloads the full period instead of adding to whatever count is left. Each action mask (none, single outputs, all three) shows that only the selected outputs fire. A disable written mid-count is contrasted with a disable captured on the expiry edge itself, and a service strobe sent before arming confirms that nothing starts.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CODE_W  = 4;
  localparam int ACT_W   = 3;
  localparam int ACT_SYS = 0;
  localparam int ACT_LOC = 1;
  localparam int ACT_BF  = 2;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int CLK_PER_US = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PRE_W = $clog2(CLK_PER_US + 1);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick_o = run_i & ~restart_i & (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (restart_i || !run_i) pre_q <= '0;
    else if (pre_q == LAST)       pre_q <= '0;
    else                          pre_q <= pre_q + 1'b1;
  end

  assert_pre_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> pre_q == '0);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick_i & ~load_i & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= period_i;
    else if (tick_i) cnt_q <= (cnt_q == CNT_W'(1)) ? period_i : cnt_q - 1'b1;
  end

  assert_cnt_live_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |-> cnt_q != '0);
endmodule

// File: rtl/wdog_fault.sv
module wdog_fault
  import wdog_pkg::*;
#(
  parameter int RST_PULSE = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             expire_i,
  input  logic [ACT_W-1:0] act_i,
  input  logic             clr_i,
  output logic [1:0]       rst_o,
  output logic             bf_o,
  output logic             timeout_o
);
  localparam int PW = $clog2(RST_PULSE + 1);
  localparam int LW = PW + 1;

  logic [ACT_W-1:0] fire;
  assign fire = {ACT_W{expire_i}} & act_i;

  for (genvar i = 0; i < 2; i++) begin : g_pulse
    logic [PW-1:0] cnt_q;
    logic [LW-1:0] hi_len;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (fire[i])         cnt_q <= PW'(RST_PULSE);
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end
    assign rst_o[i] = (cnt_q != '0);

    // high-time tracker for the pulse-width check
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        hi_len <= '0;
      else if (!rst_o[i])                 hi_len <= '0;
      else if (hi_len != {LW{1'b1}})      hi_len <= hi_len + 1'b1;
    end
    assert_pulse_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rst_o[i]) |-> hi_len >= LW'(RST_PULSE));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bf_o      <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      if (fire[ACT_BF]) bf_o <= 1'b1;
      else if (clr_i)   bf_o <= 1'b0;
      if (expire_i)     timeout_o <= 1'b1;
      else if (clr_i)   timeout_o <= 1'b0;
    end
  end

  assert_bf_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bf_o && !clr_i) |=> bf_o);
  assert_status_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> timeout_o);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int CLK_PER_US = 200,
  parameter int BASE_US    = 512,
  parameter int RST_PULSE  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  input  logic [CODE_W-1:0] cfg_period_i,
  input  logic [ACT_W-1:0]  cfg_act_i,
  input  logic              kick_i,
  input  logic              sts_clr_i,
  output logic              sys_rst_o,
  output logic              loc_rst_o,
  output logic              board_fail_o,
  output logic              timeout_o
);
  localparam int CNT_W = $clog2(BASE_US + 1) + (1 << CODE_W);

  logic              en_q;
  logic [CODE_W-1:0] code_q;
  logic [ACT_W-1:0]  act_q;
  logic              run, restart, tick, expire;
  logic [CODE_W-1:0] code_sel;
  logic [CNT_W-1:0]  period;
  logic [1:0]        rst_pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      code_q <= '0;
      act_q  <= '0;
    end else if (cfg_we_i) begin
      en_q   <= cfg_en_i;
      code_q <= cfg_period_i;
      act_q  <= cfg_act_i;
    end
  end

  // a config write suspends counting for its cycle; enabling writes also reload
  assign run      = en_q & ~cfg_we_i;
  assign restart  = cfg_we_i ? cfg_en_i : (kick_i & en_q);
  assign code_sel = cfg_we_i ? cfg_period_i : code_q;
  assign period   = CNT_W'(BASE_US) << code_sel;

  wdog_prescale #(.CLK_PER_US(CLK_PER_US)) u_pre (
    .clk_i, .rst_ni, .run_i(run), .restart_i(restart), .tick_o(tick)
  );

  wdog_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .load_i(restart), .tick_i(tick),
    .period_i(period), .expire_o(expire)
  );

  wdog_fault #(.RST_PULSE(RST_PULSE)) u_fault (
    .clk_i, .rst_ni, .expire_i(expire), .act_i(act_q), .clr_i(sts_clr_i),
    .rst_o(rst_pulse), .bf_o(board_fail_o), .timeout_o(timeout_o)
  );

  assign sys_rst_o = rst_pulse[0];
  assign loc_rst_o = rst_pulse[1];

  assert_no_expire_disarmed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q || (cfg_we_i && !cfg_en_i)) |-> !expire);
  assert_kick_holds_status_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_i && en_q && !cfg_we_i && !sts_clr_i) |=> $stable(timeout_o));
  assert_loc_selected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loc_rst_o) |-> $past(act_q[ACT_LOC]));
  assert_sys_selected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(act_q[ACT_SYS]));
endmodule

// File: tb/wdog_top_test.sv
module wdog_top_test;
  localparam int CPU = 4;
  localparam int BU  = 4;
  localparam int RP  = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 1'b0, cfg_en_i = 1'b0, kick_i = 1'b0, sts_clr_i = 1'b0;
  logic [3:0] cfg_period_i = '0;
  logic [2:0] cfg_act_i = '0;
  logic sys_rst_o, loc_rst_o, board_fail_o, timeout_o;

  always #2.5 clk_i = ~clk_i;

  wdog_top #(.CLK_PER_US(CPU), .BASE_US(BU), .RST_PULSE(RP)) uut (.*);

  int cyc = 0;
  int checks = 0, errors = 0;
  bit done = 0;
  int kind_q[$];
  int time_q[$];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver side: push expected rising events for one expiry
  task automatic expect_exp(input int t, input logic [2:0] act);
    kind_q.push_back(0); time_q.push_back(t);
    for (int i = 0; i < 3; i++)
      if (act[i]) begin kind_q.push_back(i + 1); time_q.push_back(t); end
  endtask

  // monitor: pop and compare on every rising output
  logic [3:0] prev = '0;
  int rise_at[2];
  task automatic pop_cmp(input int kind);
    if (kind_q.size() == 0) chk(1'b0, "R6 unexpected output rise, kind", kind, -1);
    else begin
      int k, t;
      k = kind_q.pop_front();
      t = time_q.pop_front();
      chk(k == kind, "R6 output kind", kind, k);
      chk(t == cyc, "R2 expiry cycle", cyc, t);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    logic [3:0] cur;
    cur = {board_fail_o, loc_rst_o, sys_rst_o, timeout_o};
    for (int i = 0; i < 4; i++) if (cur[i] && !prev[i]) pop_cmp(i);
    for (int i = 0; i < 2; i++) begin
      if (cur[i+1] && !prev[i+1]) rise_at[i] = cyc;
      if (!cur[i+1] && prev[i+1]) chk(cyc - rise_at[i] == RP, "R7 pulse width", cyc - rise_at[i], RP);
    end
    prev = cur;
  end

  task automatic wait_until(input int t);
    while (cyc < t) begin @(posedge clk_i); #1; end
  endtask

  task automatic cfg(input bit en, input logic [3:0] code, input logic [2:0] act, output int e);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_en_i = en; cfg_period_i = code; cfg_act_i = act;
    @(posedge clk_i); #1; e = cyc;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic kick(output int k);
    @(negedge clk_i); kick_i = 1'b1;
    @(posedge clk_i); #1; k = cyc;
    @(negedge clk_i); kick_i = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk_i); sts_clr_i = 1'b1;
    @(posedge clk_i); #1;
    @(negedge clk_i); sts_clr_i = 1'b0;
  endtask

  task automatic outs_zero(input string req);
    chk({sys_rst_o, loc_rst_o, board_fail_o, timeout_o} == 4'b0, req,
        {sys_rst_o, loc_rst_o, board_fail_o, timeout_o}, 0);
  endtask

  task automatic drained(input string req);
    chk(kind_q.size() == 0, req, kind_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    int e, k, d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    outs_zero("R1 reset state");

    // R5: service strobe while disarmed does nothing
    kick(k);
    wait_until(cyc + 200);
    @(negedge clk_i);
    outs_zero("R5 kick while disarmed");
    outs_zero("R1 idle while disarmed");

    // R2: code 1, system reset only
    cfg(1, 4'd1, 3'b001, e);
    expect_exp(e + 2 * BU * CPU, 3'b001);
    wait_until(e + 40);
    cfg(0, 4'd1, 3'b001, d);
    wait_until(cyc + 40);
    @(negedge clk_i);
    chk(timeout_o == 1'b1, "R9 status sticky after disarm", timeout_o, 1);
    drained("R2 expiry seen");
    clr();
    @(negedge clk_i);
    chk(timeout_o == 1'b0, "R9 status cleared", timeout_o, 0);

    // R3: code 0, local reset only
    cfg(1, 4'd0, 3'b010, e);
    expect_exp(e + BU * CPU, 3'b010);
    wait_until(e + 20);
    cfg(0, 4'd0, 3'b010, d);
    wait_until(cyc + 30);
    drained("R3 code 0 expiry");
    clr();

    // R3: code 3, no actions
    cfg(1, 4'd3, 3'b000, e);
    expect_exp(e + 8 * BU * CPU, 3'b000);
    wait_until(e + 8 * BU * CPU + 10);
    cfg(0, 4'd3, 3'b000, d);
    @(negedge clk_i);
    chk({sys_rst_o, loc_rst_o, board_fail_o} == 3'b000, "R6 empty mask",
        {sys_rst_o, loc_rst_o, board_fail_o}, 0);
    drained("R3 code 3 expiry");
    clr();

    // R4: service chain, last strobe in final cycle before expiry
    cfg(1, 4'd1, 3'b011, e);
    wait_until(e + 20);
    kick(k);
    wait_until(k + 25);
    kick(k);
    wait_until(k + 2 * BU * CPU - 2);
    kick(k);
    chk(timeout_o == 1'b0, "R4 no expiry after service", timeout_o, 0);
    expect_exp(k + 2 * BU * CPU, 3'b011);
    wait_until(k + 2 * BU * CPU + 8);
    cfg(0, 4'd1, 3'b011, d);
    wait_until(cyc + 30);
    drained("R4 expiry after last service");
    clr();

    // R8: board-fail holds until cleared
    cfg(1, 4'd0, 3'b100, e);
    expect_exp(e + BU * CPU, 3'b100);
    wait_until(e + 20);
    cfg(0, 4'd0, 3'b100, d);
    wait_until(cyc + 100);
    @(negedge clk_i);
    chk(board_fail_o == 1'b1, "R8 board-fail held", board_fail_o, 1);
    clr();
    @(negedge clk_i);
    chk(board_fail_o == 1'b0, "R8 board-fail cleared", board_fail_o, 0);
    chk(timeout_o == 1'b0, "R8 status cleared with board-fail", timeout_o, 0);
    drained("R8 expiry seen");

    // R6: all three actions
    cfg(1, 4'd0, 3'b111, e);
    expect_exp(e + BU * CPU, 3'b111);
    wait_until(e + 22);
    cfg(0, 4'd0, 3'b111, d);
    wait_until(cyc + 30);
    drained("R6 all actions fired");
    clr();

    // R10: disarm mid-count
    cfg(1, 4'd1, 3'b111, e);
    wait_until(e + 20);
    cfg(0, 4'd1, 3'b111, d);
    wait_until(cyc + 100);
    @(negedge clk_i);
    outs_zero("R10 disarm mid-count");

    // R10: disarm captured on the expiry edge
    cfg(1, 4'd1, 3'b111, e);
    wait_until(e + 2 * BU * CPU - 1);
    cfg(0, 4'd1, 3'b111, d);
    chk(d == e + 2 * BU * CPU, "R10 disarm edge alignment", d, e + 2 * BU * CPU);
    wait_until(cyc + 60);
    @(negedge clk_i);
    outs_zero("R10 disarm on expiry edge");
    drained("R10 no pending items");

    finish_run();
  end
endmodule